// File: doc/BRIEF.md
# Pipeline Hazard Detection and Bypass Unit

This unit controls hazards for an in-order pipeline of five stages. Instructions pass through fetch, decode, operand fetch, execute and write, in that order. Every cycle the unit reads a valid bit for each stage, a memory-need flag for each stage, the two source register indices of the instructions in operand fetch and execute, and the destination indices of the instructions in execute and write. From these it drives hold signals for the three front stages, bubble injection into decode or execute, the owner of the single shared memory port, and two operand bypass selects for the execute stage.

Fetch and operand fetch share one single-ported memory. When both want it in the same cycle, operand fetch gets the port, fetch is held, and an invalid slot enters decode. Read-after-write conflicts are handled in one of two ways, chosen by `fwd_en`. With bypassing on, the execute operands come from the write-stage result or from the result that retired in the previous cycle, and the youngest producer wins. With bypassing off, the dependent instruction waits in operand fetch while no-ops enter execute. It waits two cycles behind an execute-stage producer and one cycle behind a write-stage producer. A destination index of zero marks an instruction that writes nothing.

A two-state machine carries the second no-op. In `ST_FLOW` the unit compares the register indices. A match against the execute-stage producer takes the `FLOW_TO_HOLD2` transition. `ST_HOLD2` forces one more stall cycle without comparing. It returns to `ST_FLOW` by `HOLD2_TO_FLOW`, or stays in place by `HOLD2_RELOAD` if a fresh execute-stage match is present. Reset enters `ST_FLOW`.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: Reset (active-low `rst_n`) puts the sequencer in `ST_FLOW` and empties the retired-result record. With all valid bits low, every hold, bubble and grant output is 0 and both selects are 00. In the first cycle after reset, no select is 10.
- R2: `mem_to_of` is 1 exactly when the operand-fetch stage is valid (bit 2) and its memory flag (bit 2) is set. If the fetch stage (bit 0) is also valid and flags memory, `hold_if` and `bubble_id` are 1 while `hold_id` and `hold_of` stay 0. Memory flags of decode, execute and write have no effect.
- R3: With `fwd_en`=0, suppose a nonzero operand-fetch source equals the destination of a valid execute-stage instruction. Then `hold_if`, `hold_id`, `hold_of` and `bubble_ex` are 1 in that cycle and in the next, whatever the inputs of the next cycle.
- R4: With `fwd_en`=0, if an operand-fetch source matches only the destination of a valid write-stage instruction, the same four signals are 1 for that one cycle only.
- R5: Sources are compared only with destinations. Equal sources in two instructions (read after read) and matches against invalid stages cause no stall.
- R6: Register index 0 never causes a stall or a bypass, and a write with destination 0 is not recorded as a retired result.
- R7: With `fwd_en`=1 no read-after-write stall is raised. A select becomes 01 when its valid execute-stage source equals the destination of a valid write-stage instruction.
- R8: With `fwd_en`=1 a select becomes 10 when its source equals the nonzero destination that a valid write-stage instruction had in the previous cycle, and the write stage does not match now.
- R9: When a source matches both the current write-stage destination and the previous cycle's, the select is 01 (the youngest producer).
- R10: With `fwd_en`=0 both selects are 00.
- R11: When a read-after-write stall and a memory conflict occur in the same cycle, the outputs take these values. `hold_if`, `hold_id`, `hold_of` and `bubble_ex` are 1. `bubble_id` is 0. `mem_to_of` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwd_en | input | 1 | 1 selects bypassing, 0 selects no-op insertion |
| stg_vld | input | 5 | Valid bits: 0 fetch, 1 decode, 2 operand fetch, 3 execute, 4 write |
| stg_mem | input | 5 | Memory-need flags, same bit order |
| of_src_a | input | REG_W | First source of the operand-fetch instruction |
| of_src_b | input | REG_W | Second source of the operand-fetch instruction |
| ex_src_a | input | REG_W | First source of the execute instruction |
| ex_src_b | input | REG_W | Second source of the execute instruction |
| ex_dst | input | REG_W | Destination of the execute instruction (0 = none) |
| wo_dst | input | REG_W | Destination of the write-stage instruction (0 = none) |
| hold_if | output | 1 | Freeze the fetch stage |
| hold_id | output | 1 | Freeze the decode stage |
| hold_of | output | 1 | Freeze the operand-fetch stage |
| bubble_id | output | 1 | Load an invalid slot into decode |
| bubble_ex | output | 1 | Load an invalid slot into execute |
| mem_to_of | output | 1 | Memory port granted to operand fetch |
| fwd_a | output | 2 | Execute operand A source: 00 register, 01 write stage, 10 retired result |
| fwd_b | output | 2 | Execute operand B source, same encoding |

## Verification
Holds, bubbles, the grant and the 01 select all follow their inputs in the same cycle. The forced second no-op of R3 appears in the cycle after the match. A 10 select depends on the write stage of the cycle before. The bench changes inputs on the falling edge and samples one nanosecond before the next rising edge. Each row of its vector table is one cycle, and the expected values of each row account for the sequencer state and the retired record left by earlier rows.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int STG_IF = 0;
    localparam int STG_ID = 1;
    localparam int STG_OF = 2;
    localparam int STG_EX = 3;
    localparam int STG_WO = 4;
    localparam int NSTG   = 5;
    localparam int NSRC   = 2;

    typedef enum logic [1:0] {
        FWD_REG = 2'd0,
        FWD_WO  = 2'd1,
        FWD_RET = 2'd2
    } fwd_src_e;

    typedef enum logic {
        ST_FLOW  = 1'b0,
        ST_HOLD2 = 1'b1
    } raw_state_e;
endpackage

// File: rtl/hz_mem_arb.sv
module hz_mem_arb (
    input  logic if_vld,
    input  logic if_mem,
    input  logic of_vld,
    input  logic of_mem,
    output logic port_conflict,
    output logic grant_of
);
    logic if_wants;
    logic of_wants;

    always_comb begin
        if_wants      = if_vld & if_mem;
        of_wants      = of_vld & of_mem;
        grant_of      = of_wants;
        port_conflict = if_wants & of_wants;
    end
endmodule

// File: rtl/hz_raw_fsm.sv
module hz_raw_fsm
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fwd_en,
    input  logic                       of_vld,
    input  logic                       ex_vld,
    input  logic                       wo_vld,
    input  logic [NSRC-1:0][REG_W-1:0] of_src,
    input  logic [REG_W-1:0]           ex_dst,
    input  logic [REG_W-1:0]           wo_dst,
    output logic                       raw_stall
);
    localparam logic [REG_W-1:0] REG_ZERO = '0;

    raw_state_e      state_q;
    raw_state_e      state_nxt;
    logic [NSRC-1:0] hit_ex;
    logic [NSRC-1:0] hit_wo;
    logic            raw_ex;
    logic            raw_wo;

    for (genvar s = 0; s < NSRC; s++) begin : g_cmp
        assign hit_ex[s] = (of_src[s] != REG_ZERO) && (of_src[s] == ex_dst);
        assign hit_wo[s] = (of_src[s] != REG_ZERO) && (of_src[s] == wo_dst);
    end

    assign raw_ex = !fwd_en && of_vld && ex_vld && (|hit_ex);
    assign raw_wo = !fwd_en && of_vld && wo_vld && (|hit_wo);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FLOW;
        end else begin
            state_q <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_FLOW: begin
                if (raw_ex) begin
                    state_nxt = ST_HOLD2;
                end
            end
            ST_HOLD2: begin
                state_nxt = raw_ex ? ST_HOLD2 : ST_FLOW;
            end
        endcase
    end

    always_comb begin
        raw_stall = 1'b0;
        unique case (state_q)
            ST_FLOW:  raw_stall = raw_ex | raw_wo;
            ST_HOLD2: raw_stall = 1'b1;
        endcase
    end
endmodule

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fwd_en,
    input  logic                       ex_vld,
    input  logic [NSRC-1:0][REG_W-1:0] ex_src,
    input  logic                       wo_vld,
    input  logic [REG_W-1:0]           wo_dst,
    output logic [NSRC-1:0][1:0]       sel
);
    localparam logic [REG_W-1:0] REG_ZERO = '0;

    logic             ret_vld;
    logic [REG_W-1:0] ret_dst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_vld <= 1'b0;
            ret_dst <= REG_ZERO;
        end else begin
            ret_vld <= wo_vld && (wo_dst != REG_ZERO);
            ret_dst <= wo_dst;
        end
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        fwd_src_e pick;
        always_comb begin
            pick = FWD_REG;
            if (fwd_en && ex_vld && (ex_src[s] != REG_ZERO)) begin
                if (wo_vld && (wo_dst == ex_src[s])) begin
                    pick = FWD_WO;
                end else if (ret_vld && (ret_dst == ex_src[s])) begin
                    pick = FWD_RET;
                end
            end
        end
        assign sel[s] = pick;
    end
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fwd_en,
    input  logic [NSTG-1:0]  stg_vld,
    input  logic [NSTG-1:0]  stg_mem,
    input  logic [REG_W-1:0] of_src_a,
    input  logic [REG_W-1:0] of_src_b,
    input  logic [REG_W-1:0] ex_src_a,
    input  logic [REG_W-1:0] ex_src_b,
    input  logic [REG_W-1:0] ex_dst,
    input  logic [REG_W-1:0] wo_dst,
    output logic             hold_if,
    output logic             hold_id,
    output logic             hold_of,
    output logic             bubble_id,
    output logic             bubble_ex,
    output logic             mem_to_of,
    output logic [1:0]       fwd_a,
    output logic [1:0]       fwd_b
);
    logic                       port_conflict;
    logic                       raw_stall;
    logic [NSRC-1:0][REG_W-1:0] of_src;
    logic [NSRC-1:0][REG_W-1:0] ex_src;
    logic [NSRC-1:0][1:0]       sel;
    logic                       unused_flags;

    assign of_src = {of_src_b, of_src_a};
    assign ex_src = {ex_src_b, ex_src_a};
    assign unused_flags = ^{stg_vld[STG_ID], stg_mem[STG_ID], stg_mem[STG_EX], stg_mem[STG_WO]};

    hz_mem_arb u_mem_arb (
        .if_vld        (stg_vld[STG_IF]),
        .if_mem        (stg_mem[STG_IF]),
        .of_vld        (stg_vld[STG_OF]),
        .of_mem        (stg_mem[STG_OF]),
        .port_conflict (port_conflict),
        .grant_of      (mem_to_of)
    );

    hz_raw_fsm #(.REG_W(REG_W)) u_raw_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fwd_en    (fwd_en),
        .of_vld    (stg_vld[STG_OF]),
        .ex_vld    (stg_vld[STG_EX]),
        .wo_vld    (stg_vld[STG_WO]),
        .of_src    (of_src),
        .ex_dst    (ex_dst),
        .wo_dst    (wo_dst),
        .raw_stall (raw_stall)
    );

    hz_fwd_sel #(.REG_W(REG_W)) u_fwd_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .fwd_en (fwd_en),
        .ex_vld (stg_vld[STG_EX]),
        .ex_src (ex_src),
        .wo_vld (stg_vld[STG_WO]),
        .wo_dst (wo_dst),
        .sel    (sel)
    );

    // The deeper stall decides where the bubble lands; the port grant never waits on it.
    always_comb begin
        hold_of   = raw_stall;
        hold_id   = raw_stall;
        hold_if   = raw_stall | port_conflict;
        bubble_ex = raw_stall;
        bubble_id = port_conflict & ~raw_stall;
        fwd_a     = sel[0];
        fwd_b     = sel[1];
    end
endmodule

// File: rtl/pipe_hazard_ctl_chk.sv
module pipe_hazard_ctl_chk #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fwd_en,
    input logic [4:0]       stg_vld,
    input logic [4:0]       stg_mem,
    input logic [REG_W-1:0] of_src_a,
    input logic [REG_W-1:0] of_src_b,
    input logic [REG_W-1:0] ex_src_a,
    input logic [REG_W-1:0] ex_src_b,
    input logic [REG_W-1:0] ex_dst,
    input logic [REG_W-1:0] wo_dst,
    input logic             hold_if,
    input logic             hold_id,
    input logic             hold_of,
    input logic             bubble_id,
    input logic             bubble_ex,
    input logic             mem_to_of,
    input logic [1:0]       fwd_a,
    input logic [1:0]       fwd_b
);
    localparam logic [REG_W-1:0] ZR = '0;

    logic ex_match;
    logic wo_match;
    assign ex_match = !fwd_en && stg_vld[2] && stg_vld[3] && (ex_dst != ZR) &&
                      ((of_src_a == ex_dst) || (of_src_b == ex_dst));
    assign wo_match = !fwd_en && stg_vld[2] && stg_vld[4] && (wo_dst != ZR) &&
                      ((of_src_a == wo_dst) || (of_src_b == wo_dst));

    AST_PORT_TO_OF: assert property (@(posedge clk) disable iff (!rst_n) // R2
        (stg_vld[0] && stg_mem[0] && stg_vld[2] && stg_mem[2]) |-> (mem_to_of && hold_if))
        else $error("port conflict not resolved toward operand fetch");

    AST_EX_MATCH_NOW: assert property (@(posedge clk) disable iff (!rst_n) // R3
        ex_match |-> (hold_of && bubble_ex))
        else $error("execute-stage producer did not stall");

    AST_EX_MATCH_NEXT: assert property (@(posedge clk) disable iff (!rst_n) // R3
        ex_match |=> (hold_of && bubble_ex))
        else $error("second no-op missing");

    AST_WO_MATCH_NOW: assert property (@(posedge clk) disable iff (!rst_n) // R4
        wo_match |-> (hold_of && bubble_ex))
        else $error("write-stage producer did not stall");

    AST_HOLD_UPSTREAM: assert property (@(posedge clk) disable iff (!rst_n) // R11
        hold_of |-> (hold_id && hold_if && !bubble_id))
        else $error("upstream stages not frozen with operand fetch");

    AST_FWD_OFF_REG: assert property (@(posedge clk) disable iff (!rst_n) // R10
        !fwd_en |-> (fwd_a == 2'd0 && fwd_b == 2'd0))
        else $error("select active with bypassing off");

    AST_FWD_ON_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n) // R7
        (fwd_en && $past(fwd_en)) |-> !bubble_ex)
        else $error("stall raised with bypassing on");

    AST_ZERO_NO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n) // R6
        (ex_src_a == ZR) |-> (fwd_a == 2'd0))
        else $error("register zero bypassed");

    AST_YOUNGEST_WINS: assert property (@(posedge clk) disable iff (!rst_n) // R9
        (fwd_en && stg_vld[3] && stg_vld[4] && wo_dst != ZR && ex_src_a == wo_dst) |-> (fwd_a == 2'd1))
        else $error("write-stage producer not chosen");

    AST_RET_IS_LAST_WO: assert property (@(posedge clk) disable iff (!rst_n) // R8
        (fwd_a == 2'd2) |-> ($past(stg_vld[4]) && $past(wo_dst) == ex_src_a))
        else $error("retired select without matching previous write");
endmodule

bind pipe_hazard_ctl pipe_hazard_ctl_chk #(.REG_W(REG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .stg_vld(stg_vld), .stg_mem(stg_mem),
    .of_src_a(of_src_a), .of_src_b(of_src_b), .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
    .ex_dst(ex_dst), .wo_dst(wo_dst), .hold_if(hold_if), .hold_id(hold_id),
    .hold_of(hold_of), .bubble_id(bubble_id), .bubble_ex(bubble_ex),
    .mem_to_of(mem_to_of), .fwd_a(fwd_a), .fwd_b(fwd_b)
);

// File: tb/test_pipe_hazard_ctl.sv
module test_pipe_hazard_ctl;
    localparam int RW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          fwd_en;
    logic [4:0]    stg_vld, stg_mem;
    logic [RW-1:0] of_src_a, of_src_b, ex_src_a, ex_src_b, ex_dst, wo_dst;
    logic          hold_if, hold_id, hold_of, bubble_id, bubble_ex, mem_to_of;
    logic [1:0]    fwd_a, fwd_b;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    pipe_hazard_ctl #(.REG_W(RW)) i_pipe_hazard_ctl (
        .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .stg_vld(stg_vld), .stg_mem(stg_mem),
        .of_src_a(of_src_a), .of_src_b(of_src_b), .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
        .ex_dst(ex_dst), .wo_dst(wo_dst), .hold_if(hold_if), .hold_id(hold_id),
        .hold_of(hold_of), .bubble_id(bubble_id), .bubble_ex(bubble_ex),
        .mem_to_of(mem_to_of), .fwd_a(fwd_a), .fwd_b(fwd_b)
    );

    // hold = {of,id,if}, bub = {ex,id}
    typedef struct packed {
        logic       fe;
        logic [4:0] vld;
        logic [4:0] mem;
        logic [4:0] oa, ob, ea, eb, ed, wd;
        logic [2:0] x_hold;
        logic [1:0] x_bub;
        logic       x_mof;
        logic [1:0] x_fa, x_fb;
        logic [3:0] rq;
    } vec_t;

    localparam int NVEC = 26;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0,5'b00000,5'b00000,5'd0,5'd0,5'd0,5'd0,5'd0,5'd0,3'b000,2'b00,1'b0,2'd0,2'd0,4'd1},  // R1 idle
        '{1'b1,5'b01000,5'b00000,5'd0,5'd0,5'd5,5'd0,5'd0,5'd0,3'b000,2'b00,1'b0,2'd0,2'd0,4'd1},  // R1 no retired value
        '{1'b1,5'b11000,5'b00000,5'd0,5'd0,5'd7,5'd3,5'd0,5'd7,3'b000,2'b00,1'b0,2'd1,2'd0,4'd7},  // R7
        '{1'b1,5'b01000,5'b00000,5'd0,5'd0,5'd9,5'd7,5'd0,5'd0,3'b000,2'b00,1'b0,2'd0,2'd2,4'd8},  // R8
        '{1'b1,5'b11000,5'b00000,5'd0,5'd0,5'd1,5'd2,5'd0,5'd4,3'b000,2'b00,1'b0,2'd0,2'd0,4'd7},  // R7 no match
        '{1'b1,5'b11000,5'b00000,5'd0,5'd0,5'd4,5'd4,5'd0,5'd4,3'b000,2'b00,1'b0,2'd1,2'd1,4'd9},  // R9
        '{1'b1,5'b11000,5'b00000,5'd0,5'd0,5'd0,5'd0,5'd0,5'd0,3'b000,2'b00,1'b0,2'd0,2'd0,4'd6},  // R6 src 0
        '{1'b1,5'b11000,5'b00000,5'd0,5'd0,5'd4,5'd0,5'd0,5'd0,3'b000,2'b00,1'b0,2'd0,2'd0,4'd6},  // R6 dst 0 not recorded
        '{1'b0,5'b01100,5'b00000,5'd0,5'd0,5'd0,5'd0,5'd0,5'd0,3'b000,2'b00,1'b0,2'd0,2'd0,4'd6},  // R6 no stall
        '{1'b0,5'b11000,5'b00000,5'd0,5'd0,5'd3,5'd0,5'd0,5'd3,3'b000,2'b00,1'b0,2'd0,2'd0,4'd10}, // R10
        '{1'b0,5'b11000,5'b00000,5'd0,5'd0,5'd3,5'd0,5'd0,5'd3,3'b000,2'b00,1'b0,2'd0,2'd0,4'd10}, // R10
        '{1'b0,5'b00101,5'b00101,5'd0,5'd0,5'd0,5'd0,5'd0,5'd0,3'b001,2'b01,1'b1,2'd0,2'd0,4'd2},  // R2 conflict
        '{1'b1,5'b11111,5'b11010,5'd0,5'd0,5'd0,5'd0,5'd0,5'd0,3'b000,2'b00,1'b0,2'd0,2'd0,4'd2},  // R2 other flags
        '{1'b0,5'b00100,5'b00100,5'd0,5'd0,5'd0,5'd0,5'd0,5'd0,3'b000,2'b00,1'b1,2'd0,2'd0,4'd2},  // R2 OF alone
        '{1'b0,5'b00001,5'b00101,5'd0,5'd0,5'd0,5'd0,5'd0,5'd0,3'b000,2'b00,1'b0,2'd0,2'd0,4'd2},  // R2 OF invalid
        '{1'b0,5'b01100,5'b00000,5'd6,5'd1,5'd0,5'd0,5'd6,5'd0,3'b111,2'b10,1'b0,2'd0,2'd0,4'd3},  // R3 first
        '{1'b0,5'b00100,5'b00000,5'd6,5'd0,5'd0,5'd0,5'd0,5'd0,3'b111,2'b10,1'b0,2'd0,2'd0,4'd3},  // R3 forced second
        '{1'b0,5'b00100,5'b00000,5'd6,5'd0,5'd0,5'd0,5'd0,5'd0,3'b000,2'b00,1'b0,2'd0,2'd0,4'd3},  // R3 released
        '{1'b0,5'b10100,5'b00000,5'd2,5'd8,5'd0,5'd0,5'd0,5'd8,3'b111,2'b10,1'b0,2'd0,2'd0,4'd4},  // R4
        '{1'b0,5'b00100,5'b00000,5'd0,5'd8,5'd0,5'd0,5'd0,5'd0,3'b000,2'b00,1'b0,2'd0,2'd0,4'd4},  // R4 one cycle
        '{1'b0,5'b01100,5'b00000,5'd3,5'd4,5'd3,5'd4,5'd9,5'd0,3'b000,2'b00,1'b0,2'd0,2'd0,4'd5},  // R5 read after read
        '{1'b0,5'b00100,5'b00000,5'd9,5'd0,5'd0,5'd0,5'd9,5'd0,3'b000,2'b00,1'b0,2'd0,2'd0,4'd5},  // R5 invalid EX
        '{1'b0,5'b01101,5'b00101,5'd5,5'd0,5'd0,5'd0,5'd5,5'd0,3'b111,2'b10,1'b1,2'd0,2'd0,4'd11}, // R11
        '{1'b0,5'b10101,5'b00101,5'd5,5'd0,5'd0,5'd0,5'd0,5'd5,3'b111,2'b10,1'b1,2'd0,2'd0,4'd11}, // R11
        '{1'b0,5'b00100,5'b00000,5'd5,5'd0,5'd0,5'd0,5'd0,5'd0,3'b000,2'b00,1'b0,2'd0,2'd0,4'd11}, // R11 clear
        '{1'b1,5'b01100,5'b00000,5'd2,5'd0,5'd1,5'd1,5'd2,5'd0,3'b000,2'b00,1'b0,2'd0,2'd0,4'd7}   // R7 no stall
    };

    task automatic check_out(input int rq, input string what, input logic [2:0] xh,
                             input logic [1:0] xb, input logic xm, input logic [1:0] xa,
                             input logic [1:0] xbsel);
        logic [9:0] act, exp;
        act = {hold_of, hold_id, hold_if, bubble_ex, bubble_id, mem_to_of, fwd_a, fwd_b};
        exp = {xh, xb, xm, xa, xbsel};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual %b expected %b", rq, what, act, exp);
        end
    endtask

    task automatic put(input logic fe, input logic [4:0] vld, input logic [4:0] mem,
                       input logic [4:0] oa, input logic [4:0] ea, input logic [4:0] ed,
                       input logic [4:0] wd);
        fwd_en = fe; stg_vld = vld; stg_mem = mem;
        of_src_a = oa; of_src_b = '0; ex_src_a = ea; ex_src_b = '0; ex_dst = ed; wo_dst = wd;
    endtask

    initial begin
        rst_n = 1'b0;
        put(1'b0, 5'b0, 5'b0, 5'd0, 5'd0, 5'd0, 5'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NVEC; k++) begin
            @(negedge clk);
            fwd_en = VEC[k].fe; stg_vld = VEC[k].vld; stg_mem = VEC[k].mem;
            of_src_a = VEC[k].oa; of_src_b = VEC[k].ob;
            ex_src_a = VEC[k].ea; ex_src_b = VEC[k].eb;
            ex_dst = VEC[k].ed; wo_dst = VEC[k].wd;
            #4;
            check_out(int'(VEC[k].rq), $sformatf("row %0d", k), VEC[k].x_hold, VEC[k].x_bub,
                      VEC[k].x_mof, VEC[k].x_fa, VEC[k].x_fb);
        end

        // R1: reset in the middle of a two-cycle stall clears the sequencer
        @(negedge clk);
        put(1'b0, 5'b01100, 5'b0, 5'd6, 5'd0, 5'd6, 5'd0);
        #4 check_out(3, "stall before reset", 3'b111, 2'b10, 1'b0, 2'd0, 2'd0);
        @(negedge clk);
        rst_n = 1'b0;
        put(1'b0, 5'b00100, 5'b0, 5'd6, 5'd0, 5'd0, 5'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #4 check_out(1, "no stall after reset", 3'b000, 2'b00, 1'b0, 2'd0, 2'd0);

        // R1: reset empties the retired-result record
        @(negedge clk);
        put(1'b1, 5'b10000, 5'b0, 5'd0, 5'd0, 5'd0, 5'd7);
        @(negedge clk);
        rst_n = 1'b0;
        put(1'b1, 5'b01000, 5'b0, 5'd0, 5'd7, 5'd0, 5'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #4 check_out(1, "retired record after reset", 3'b000, 2'b00, 1'b0, 2'd0, 2'd0);

        // R8: same record without reset gives the retired select
        @(negedge clk);
        put(1'b1, 5'b10000, 5'b0, 5'd0, 5'd0, 5'd0, 5'd7);
        @(negedge clk);
        put(1'b1, 5'b01000, 5'b0, 5'd0, 5'd7, 5'd0, 5'd0);
        #4 check_out(8, "retired select", 3'b000, 2'b00, 1'b0, 2'd2, 2'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule